// File: doc/BRIEF.md
# CAN Integration Idle Detector

This block decides when a CAN receive path may treat the bus as idle. It is used after the controller leaves its configuration hold, and again after a protocol exception. While it is in the integrating state it counts recessive bits. It takes the sample value at each sample point, where a sample point is marked by a sample strobe that coincides with a time-quantum strobe from the bit-timing unit. When the count reaches eleven consecutive recessive bits, the block leaves integration and issues a single-cycle idle pulse.

An optional spike filter runs only while integrating. Dominant activity restarts the recessive count only when it lasts two or more consecutive time quanta. The filtered, delayed receive value is what the block hands downstream during that time. Once integration ends, the filter drops out and the raw receive input passes straight through. Three controls select when integration starts: a configuration hold input, a protocol-exception event, and a bit that disables exception handling.

Top module: `can_idle_detector`

## Requirements
- R1: After reset, `integrating` and `idle_pulse` are 0. The block is in the hold state, and `rx_filt` equals `rx_in`.
- R2: While `init_hold` is 1, in the following cycle `integrating` is 0 and `idle_pulse` is 0, whatever `rx_in` does. Raising `init_hold` during integration ends integration in the next cycle.
- R3: When `init_hold` goes from 1 to 0, `integrating` is 1 in the next cycle, and the recessive count starts from zero.
- R4: With `init_hold` 0, a `proto_exc` pulse while `exc_hold_dis` is 0 sets `integrating` in the next cycle and restarts the recessive count at zero. While `exc_hold_dis` is 1, the pulse has no effect.
- R5: A sample point is a cycle with both `tq_en` and `sp_en` high; a recessive sample is `rx_in` = 1. At the eleventh counted recessive sample point, `idle_pulse` is 1 for exactly the next cycle, and `integrating` is 0 from that same cycle.
- R6: With `spike_filt_en` 0, a dominant value at a sample point restarts the count at zero. Dominant quanta that fall between sample points do not affect the count.
- R7: With `spike_filt_en` 1, a dominant value lasting a single time quantum does not restart the count, even when it falls on a sample point. That sample point counts as recessive.
- R8: With `spike_filt_en` 1, a second consecutive dominant time quantum restarts the count at zero. This holds whether or not the quantum is a sample point.
- R9: With filtering active, `rx_filt` is a registered value. It stays 1 through a one-quantum dominant pulse. It goes to 0 in the cycle after the second consecutive dominant quantum strobe.
- R10: When the block is not integrating, or when `spike_filt_en` is 0, `rx_filt` equals `rx_in` in the same cycle.
- R11: Counting and filter state change only on cycles with `tq_en` high. `sp_en` or a dominant `rx_in` without `tq_en` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_in | input | 1 | Synchronised receive value (1 = recessive) |
| tq_en | input | 1 | Time-quantum strobe |
| sp_en | input | 1 | Sample-point marker, valid with `tq_en` |
| spike_filt_en | input | 1 | Enables the spike filter during integration |
| init_hold | input | 1 | Configuration hold; a falling edge starts integration |
| proto_exc | input | 1 | Protocol-exception event pulse |
| exc_hold_dis | input | 1 | 1 blocks integration entry on `proto_exc` |
| integrating | output | 1 | High while counting recessive bits for idle |
| idle_pulse | output | 1 | One-cycle pulse when bus idle is reached |
| rx_filt | output | 1 | Receive value for downstream bit timing |

## Verification
The main function is driven with several bit patterns:
- A clean run of recessive bits, with the idle pulse expected exactly at the eleventh sample point.
- One dominant bit at a sample point, applied once with the filter off and once with it on. This separates a true count restart from a filtered spike.
- Two dominant quanta ahead of a recessive sample point, applied once in each filter mode. This separates quanta that fall between sample points from a qualified dominant run.

Further runs cover:
- exception entry with handling enabled and with it disabled;
- sample strobes without a quantum strobe;
- pass-through of `rx_filt` once integration has ended.

// File: rtl/can_idle_pkg.sv
package can_idle_pkg;

  typedef enum logic [1:0] {
    ST_HELD   = 2'd0,
    ST_INTEG  = 2'd1,
    ST_ACTIVE = 2'd2
  } integ_state_e;

  // saturating increment on plain integers; callers cast to their width
  function automatic int unsigned sat_next(int unsigned val, int unsigned limit);
    return (val >= limit) ? limit : val + 1;
  endfunction

  // true when a count value is the last one before the target
  function automatic logic is_final(int unsigned val, int unsigned target);
    return val == target - 1;
  endfunction

endpackage

// File: rtl/can_idle_edge_filter.sv
module can_idle_edge_filter
  import can_idle_pkg::*;
#(
  parameter int unsigned DOM_MIN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tq_en,
  input  logic sp_hit,
  input  logic rx_in,
  input  logic filt_on,
  output logic dom_hit,
  output logic rx_out
);

  localparam int unsigned RUN_W = $clog2(DOM_MIN + 1);
  localparam logic [RUN_W-1:0] RUN_QUAL = RUN_W'(DOM_MIN - 1);

  logic [RUN_W-1:0] run_q;
  logic             filt_q;
  logic             run_ok;

  assign run_ok = (run_q >= RUN_QUAL);

  // qualified dominant event that restarts the recessive count
  assign dom_hit = filt_on ? (tq_en && !rx_in && run_ok) : (sp_hit && !rx_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      filt_q <= 1'b1;
    end else if (!filt_on) begin
      run_q  <= '0;
      filt_q <= 1'b1;
    end else if (tq_en) begin
      if (rx_in) begin
        run_q  <= '0;
        filt_q <= 1'b1;
      end else begin
        run_q <= RUN_W'(sat_next(int'(run_q), DOM_MIN));
        if (run_ok) filt_q <= 1'b0;
      end
    end
  end

  assign rx_out = filt_on ? filt_q : rx_in;

  assert_spike_hidden_R9 : assert property (@(posedge clk) disable iff (!rst_n)
    (filt_on && tq_en && !rx_in && run_q == '0 && filt_q) |=> filt_q);

  assert_run_saturates_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RUN_W'(DOM_MIN));

  assert_run_idle_no_tq_R11 : assert property (@(posedge clk) disable iff (!rst_n)
    (filt_on && !tq_en) |=> $stable(run_q) || !filt_on);

endmodule

// File: rtl/can_idle_bit_counter.sv
module can_idle_bit_counter
  import can_idle_pkg::*;
#(
  parameter int unsigned REC_BITS = 11
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clear,
  input  logic                        sp_hit,
  input  logic                        dom_hit,
  output logic [$clog2(REC_BITS)-1:0] cnt,
  output logic                        last_hit
);

  localparam int unsigned CNT_W = $clog2(REC_BITS);

  logic [CNT_W-1:0] cnt_q;

  assign last_hit = !clear && sp_hit && !dom_hit && is_final(int'(cnt_q), REC_BITS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear || dom_hit) begin
      cnt_q <= '0;
    end else if (sp_hit) begin
      cnt_q <= last_hit ? '0 : cnt_q + CNT_W'(1);
    end
  end

  assign cnt = cnt_q;

  assert_cnt_bound_R5 : assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(REC_BITS - 1));

  assert_cleared_zero_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> cnt_q == '0);

endmodule

// File: rtl/can_idle_ctrl.sv
module can_idle_ctrl
  import can_idle_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic init_hold,
  input  logic exc_evt,
  input  logic exc_hold_dis,
  input  logic last_hit,
  output logic integrating,
  output logic idle_pulse,
  output logic enter_evt
);

  integ_state_e state_q;
  logic         idle_q;
  logic         exc_ok;

  assign exc_ok    = exc_evt && !exc_hold_dis;
  assign enter_evt = !init_hold && ((state_q == ST_HELD) || exc_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HELD;
      idle_q  <= 1'b0;
    end else begin
      idle_q <= 1'b0;
      if (init_hold) begin
        state_q <= ST_HELD;
      end else if (enter_evt) begin
        state_q <= ST_INTEG;
      end else if (state_q == ST_INTEG && last_hit) begin
        state_q <= ST_ACTIVE;
        idle_q  <= 1'b1;
      end
    end
  end

  assign integrating = (state_q == ST_INTEG);
  assign idle_pulse  = idle_q;

  assert_init_holds_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    init_hold |=> (!integrating && !idle_pulse));

  assert_enter_on_release_R3 : assert property (@(posedge clk) disable iff (!rst_n)
    $fell(init_hold) |=> integrating);

  assert_exc_enters_R4 : assert property (@(posedge clk) disable iff (!rst_n)
    (!init_hold && exc_evt && !exc_hold_dis) |=> integrating);

  assert_exc_blocked_R4 : assert property (@(posedge clk) disable iff (!rst_n)
    (exc_evt && exc_hold_dis && !init_hold && state_q == ST_ACTIVE) |=> !integrating);

  assert_pulse_single_R5 : assert property (@(posedge clk) disable iff (!rst_n)
    idle_pulse |=> !idle_pulse);

  assert_pulse_leaves_R5 : assert property (@(posedge clk) disable iff (!rst_n)
    idle_pulse |-> !integrating);

endmodule

// File: rtl/can_idle_detector.sv
module can_idle_detector
  import can_idle_pkg::*;
#(
  parameter int unsigned REC_BITS = 11,
  parameter int unsigned DOM_MIN  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_in,
  input  logic tq_en,
  input  logic sp_en,
  input  logic spike_filt_en,
  input  logic init_hold,
  input  logic proto_exc,
  input  logic exc_hold_dis,
  output logic integrating,
  output logic idle_pulse,
  output logic rx_filt
);

  localparam int unsigned CNT_W = $clog2(REC_BITS);

  // named internal events
  logic             sp_hit;
  logic             filt_on;
  logic             dom_hit;
  logic             last_hit;
  logic             enter_evt;
  logic             cnt_clear;
  logic [CNT_W-1:0] rec_cnt;

  assign sp_hit    = tq_en && sp_en;
  assign filt_on   = integrating && spike_filt_en;
  assign cnt_clear = !integrating || enter_evt || init_hold;

  can_idle_edge_filter #(.DOM_MIN(DOM_MIN)) u_filter (
    .clk     (clk),
    .rst_n   (rst_n),
    .tq_en   (tq_en),
    .sp_hit  (sp_hit),
    .rx_in   (rx_in),
    .filt_on (filt_on),
    .dom_hit (dom_hit),
    .rx_out  (rx_filt)
  );

  can_idle_bit_counter #(.REC_BITS(REC_BITS)) u_counter (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (cnt_clear),
    .sp_hit   (sp_hit),
    .dom_hit  (dom_hit),
    .cnt      (rec_cnt),
    .last_hit (last_hit)
  );

  can_idle_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .init_hold    (init_hold),
    .exc_evt      (proto_exc),
    .exc_hold_dis (exc_hold_dis),
    .last_hit     (last_hit),
    .integrating  (integrating),
    .idle_pulse   (idle_pulse),
    .enter_evt    (enter_evt)
  );

  assert_dom_sample_restarts_R6 : assert property (@(posedge clk) disable iff (!rst_n)
    (integrating && !spike_filt_en && sp_hit && !rx_in && !init_hold) |=> rec_cnt == '0);

  assert_qual_run_restarts_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    (filt_on && dom_hit && !init_hold) |=> rec_cnt == '0);

  assert_count_waits_tq_R11 : assert property (@(posedge clk) disable iff (!rst_n)
    (integrating && !tq_en && !enter_evt && !init_hold) |=> $stable(rec_cnt));

  assert_exc_restarts_R4 : assert property (@(posedge clk) disable iff (!rst_n)
    (!init_hold && proto_exc && !exc_hold_dis) |=> rec_cnt == '0);

endmodule

// File: tb/can_idle_detector_bench.sv
module can_idle_detector_bench;

  localparam int CLK_PERIOD = 10;
  localparam int SP_TQ      = 2;
  localparam int BIT_TQ     = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_in = 1'b1, tq_en = 1'b0, sp_en = 1'b0, spike_filt_en = 1'b0;
  logic init_hold = 1'b1, proto_exc = 1'b0, exc_hold_dis = 1'b0;
  logic integrating, idle_pulse, rx_filt;

  int n_checks = 0, n_fail = 0, n_pulses = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_idle_detector u_can_idle_detector (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .tq_en(tq_en), .sp_en(sp_en),
    .spike_filt_en(spike_filt_en), .init_hold(init_hold), .proto_exc(proto_exc),
    .exc_hold_dis(exc_hold_dis), .integrating(integrating), .idle_pulse(idle_pulse),
    .rx_filt(rx_filt)
  );

  always @(negedge clk) if (rst_n && idle_pulse) n_pulses++;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  // one time quantum: strobe cycle then a quiet cycle; returns 1 time unit after the edge
  task automatic quantum(input bit rxv, input bit sp);
    @(negedge clk);
    rx_in = rxv; tq_en = 1'b1; sp_en = sp;
    @(negedge clk);
    tq_en = 1'b0; sp_en = 1'b0;
    #1;
  endtask

  task automatic send_bit(input logic [3:0] dmask, output bit pulse_at_sp);
    pulse_at_sp = 1'b0;
    for (int q = 0; q < BIT_TQ; q++) begin
      quantum(!dmask[q], q == SP_TQ);
      if (q == SP_TQ) pulse_at_sp = idle_pulse;
    end
  endtask

  // returns the 1-based index of the bit whose sample point pulsed, 0 if none
  task automatic send_rec(input int n, output int first);
    bit p;
    first = 0;
    for (int b = 1; b <= n; b++) begin
      send_bit(4'b0000, p);
      if (p && first == 0) first = b;
    end
  endtask

  task automatic start_integ(input bit filt);
    @(negedge clk); init_hold = 1'b1; spike_filt_en = filt; rx_in = 1'b1;
    repeat (2) @(negedge clk);
    init_hold = 1'b0;
    @(negedge clk); #1;
    check(integrating == 1'b1, "R3", "integrating after release", integrating, 1);
  endtask

  task automatic t_reset();
    check(integrating == 1'b0, "R1", "integrating after reset", integrating, 0);
    check(idle_pulse == 1'b0, "R1", "idle_pulse after reset", idle_pulse, 0);
    check(rx_filt == 1'b1, "R1", "rx_filt after reset", rx_filt, 1);
    rx_in = 1'b0; #1;
    check(rx_filt == 1'b0, "R10", "pass-through in hold", rx_filt, 0);
    rx_in = 1'b1; #1;
  endtask

  task automatic t_init_hold();
    int first, p0;
    p0 = n_pulses;
    send_rec(15, first);
    check(n_pulses == p0, "R2", "pulses while held", n_pulses - p0, 0);
    check(integrating == 1'b0, "R2", "integrating while held", integrating, 0);
    start_integ(1'b0);
    send_rec(5, first);
    @(negedge clk); init_hold = 1'b1;
    @(negedge clk); #1;
    check(integrating == 1'b0, "R2", "init ends integration", integrating, 0);
  endtask

  task automatic t_basic();
    int first, p0;
    bit p;
    start_integ(1'b0);
    p0 = n_pulses;
    send_rec(10, first);
    check(first == 0, "R5", "no pulse before 11th bit", first, 0);
    check(integrating == 1'b1, "R5", "still integrating after 10", integrating, 1);
    send_bit(4'b0000, p);
    check(p == 1'b1, "R5", "pulse at 11th sample", p, 1);
    repeat (4) @(negedge clk);
    #1;
    check(n_pulses - p0 == 1, "R5", "single-cycle pulse", n_pulses - p0, 1);
    check(integrating == 1'b0, "R5", "integration left", integrating, 0);
  endtask

  task automatic t_dom_nofilt();
    int first;
    bit p;
    start_integ(1'b0);
    send_rec(5, first);
    send_bit(4'b0100, p);
    send_rec(11, first);
    check(first == 11, "R6", "restart on dominant sample", first, 11);
    start_integ(1'b0);
    send_rec(5, first);
    send_bit(4'b0011, p);
    send_rec(5, first);
    check(first == 5, "R6", "dominant off sample ignored", first, 5);
  endtask

  task automatic t_spike_filter();
    int first;
    start_integ(1'b1);
    send_rec(5, first);
    quantum(1'b1, 1'b0);
    quantum(1'b1, 1'b0);
    quantum(1'b0, 1'b1);
    check(rx_filt == 1'b1 && rx_in == 1'b0, "R9", "spike hidden on rx_filt", rx_filt, 1);
    quantum(1'b1, 1'b0);
    send_rec(5, first);
    check(first == 5, "R7", "spike sample counts recessive", first, 5);
  endtask

  task automatic t_two_dom();
    int first;
    start_integ(1'b1);
    send_rec(5, first);
    quantum(1'b0, 1'b0);
    check(rx_filt == 1'b1, "R9", "rx_filt after first dominant tq", rx_filt, 1);
    quantum(1'b0, 1'b0);
    check(rx_filt == 1'b0, "R9", "rx_filt after second dominant tq", rx_filt, 0);
    quantum(1'b1, 1'b1);
    quantum(1'b1, 1'b0);
    send_rec(10, first);
    check(first == 10, "R8", "restart on two dominant tq", first, 10);
    @(negedge clk); rx_in = 1'b0; #1;
    check(rx_filt == 1'b0, "R10", "pass-through after idle", rx_filt, 0);
    rx_in = 1'b1; #1;
    start_integ(1'b0);
    rx_in = 1'b0; #1;
    check(rx_filt == 1'b0, "R10", "pass-through filter off", rx_filt, 0);
    rx_in = 1'b1; #1;
  endtask

  task automatic pulse_exc(input bit dis);
    @(negedge clk); exc_hold_dis = dis; proto_exc = 1'b1;
    @(negedge clk); proto_exc = 1'b0; #1;
  endtask

  task automatic t_exception();
    int first;
    start_integ(1'b0);
    send_rec(11, first);
    pulse_exc(1'b1);
    check(integrating == 1'b0, "R4", "exception blocked", integrating, 0);
    pulse_exc(1'b0);
    check(integrating == 1'b1, "R4", "exception enters", integrating, 1);
    send_rec(6, first);
    pulse_exc(1'b0);
    send_rec(10, first);
    check(first == 0, "R4", "exception restarts count", first, 0);
    send_rec(1, first);
    check(first == 1, "R4", "idle after restart", first, 1);
    exc_hold_dis = 1'b0;
  endtask

  task automatic t_no_tq();
    int first;
    start_integ(1'b0);
    send_rec(5, first);
    @(negedge clk); rx_in = 1'b0; sp_en = 1'b1;
    repeat (6) @(negedge clk);
    rx_in = 1'b1; sp_en = 1'b0;
    send_rec(5, first);
    check(first == 0, "R11", "no early pulse", first, 0);
    send_rec(1, first);
    check(first == 1, "R11", "strobe without tq ignored", first, 1);
    start_integ(1'b1);
    @(negedge clk); rx_in = 1'b0;
    repeat (5) @(negedge clk);
    #1;
    check(rx_filt == 1'b1, "R11", "filter idle without tq", rx_filt, 1);
    rx_in = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    t_reset();
    t_init_hold();
    t_basic();
    t_dom_nofilt();
    t_spike_filter();
    t_two_dom();
    t_exception();
    t_no_tq();
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
    $finish;
  end

endmodule